// File: doc/BRIEF.md
# Serial Configuration ROM Read Responder

This block plays the memory side of a software-driven serial link. A host writes a small control word (select, serial clock, serial data-in) through a single write strobe. The block keeps the previous control value and treats every change between consecutive writes as a line event. A transaction begins when select goes high. The first serial clock rise after that is a start bit. The next eight rises shift in a command, most significant bit first. For a read command, the following rises return a 16-bit word one bit at a time on a data-out line, most significant bit first.

The word comes from a 256-byte constant image, which is a parameter loaded at reset. Each command addresses a pair of bytes. Bytes 0 to 5 of the image hold the station address. Commands that are not reads are not carried out. They raise a sticky flag. Clocking past the end of a word raises a second sticky flag.

Top module: `serial_rom_responder`

## Requirements
- R1: After reset, `sdo_o`, `overread_o` and `unsup_cmd_o` are all 0.
- R2: A control write with select low returns the block to idle. Later serial clock rises leave `sdo_o` unchanged until select rises again.
- R3: A rise of select moves idle to a waiting state. The next serial clock rise is taken as the start bit, and its data value is ignored. Select and clock may both rise in one write, and that write counts as the start bit.
- R4: After the start bit, the next 8 serial clock rises each shift the data-in bit into the command, first bit landing in command bit 7.
- R5: A command with bit 7 = 1 is a read. Its byte address is command bits 6..0 shifted left by one. The returned word is (byte[address] * 256) + byte[address + 1].
- R6: During a read, each serial clock rise puts the next word bit on `sdo_o`, most significant first. `sdo_o` changes only on such a rise, and it is visible in the cycle after the write.
- R7: A 17th or later serial clock rise in one read sets `overread_o` and drives `sdo_o` to 0. The flag stays set until reset.
- R8: A command with bit 7 = 0 sets `unsup_cmd_o` until reset and returns to idle. Clock rises then leave `sdo_o` unchanged until select is raised again. A later read transaction still works.
- R9: Edges are found only between consecutive control writes. A write that repeats a high clock is not a rise, and with no write nothing changes.
- R10: The byte image is the `INIT_IMAGE` parameter, with byte i at bits [8i+7:8i]. Bytes 0 to 5 are the station address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_sel_i | input | 1 | Select value written |
| ctrl_sclk_i | input | 1 | Serial clock value written |
| ctrl_sdi_i | input | 1 | Serial data-in value written |
| sdo_o | output | 1 | Serial data-out bit |
| overread_o | output | 1 | Sticky: read clocked past word end |
| unsup_cmd_o | output | 1 | Sticky: non-read command received |

## Verification
Every internal state defect shows up at `sdo_o` within one control write of a clock rise. If the sequencer is in the wrong state or the bit counter is off, the returned bit stream starts early or late, which shifts the expected word by one or more positions. If the address is decoded wrongly or the byte order is swapped, the read returns different image bytes. If edge detection or the abort path is faulty, `sdo_o` moves on a write where it must hold. Flag faults appear the cycle after the write that triggers them.

// File: rtl/srr_pkg.sv
package srr_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READY = 2'd1,
      ST_CMD   = 2'd2,
      ST_READ  = 2'd3
   } srr_state_e;

   localparam int unsigned DEF_ADDR_BITS = 7;
   localparam int unsigned DEF_BYTE_BITS = 8;
   localparam int unsigned DEF_DEPTH     = 1 << (DEF_ADDR_BITS + 1);
   localparam int unsigned DEF_IMG_W     = DEF_DEPTH * DEF_BYTE_BITS;

   // Default image: a fixed station address in bytes 0..5, a filler pattern after it.
   function automatic logic [DEF_IMG_W-1:0] default_image();
      logic [DEF_IMG_W-1:0] img;
      logic [47:0]          station;
      station = 48'h02_00_5E_10_20_30;
      img     = '0;
      for (int i = 0; i < DEF_DEPTH; i++) begin
         if (i < 6) img[i*8 +: 8] = station[47 - i*8 -: 8];
         else       img[i*8 +: 8] = 8'(i) ^ 8'h5A;
      end
      return img;
   endfunction

endpackage

// File: rtl/srr_ctrl_edge.sv
module srr_ctrl_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_i,
   input  logic sel_i,
   input  logic sclk_i,
   output logic sel_rise_o,
   output logic sel_drop_o,
   output logic sclk_rise_o
);

   logic sel_q, sclk_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sel_q  <= 1'b0;
         sclk_q <= 1'b0;
      end else if (wr_i) begin
         sel_q  <= sel_i;
         sclk_q <= sclk_i;
      end
   end

   assign sel_rise_o  = wr_i &  sel_i  & ~sel_q;
   assign sel_drop_o  = wr_i & ~sel_i;
   assign sclk_rise_o = wr_i &  sclk_i & ~sclk_q;

endmodule

// File: rtl/srr_word_rom.sv
module srr_word_rom #(
   parameter int unsigned ADDR_BITS  = 7,
   parameter int unsigned BYTE_BITS  = 8,
   parameter bit          REG_STORE  = 1'b0,
   parameter int unsigned DEPTH      = 1 << (ADDR_BITS + 1),
   parameter logic [DEPTH*BYTE_BITS-1:0] IMAGE = '0
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [ADDR_BITS-1:0]   word_addr_i,
   output logic [2*BYTE_BITS-1:0] word_o
);

   localparam int unsigned BADDR_W = ADDR_BITS + 1;

   logic [BADDR_W-1:0] hi_addr, lo_addr;

   assign hi_addr = {word_addr_i, 1'b0};
   assign lo_addr = {word_addr_i, 1'b1};

   initial begin
      assert (DEPTH == (1 << BADDR_W))
         else $error("srr_word_rom: DEPTH must cover the byte address space");
   end

   generate
      if (REG_STORE) begin : g_flops
         logic [BYTE_BITS-1:0] mem_q [DEPTH];
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               for (int i = 0; i < DEPTH; i++) mem_q[i] <= IMAGE[i*BYTE_BITS +: BYTE_BITS];
            end
         end
         assign word_o = {mem_q[hi_addr], mem_q[lo_addr]};
      end else begin : g_const
         assign word_o = {IMAGE[int'(hi_addr)*BYTE_BITS +: BYTE_BITS],
                          IMAGE[int'(lo_addr)*BYTE_BITS +: BYTE_BITS]};
      end
   endgenerate

endmodule

// File: rtl/srr_seq.sv
module srr_seq
   import srr_pkg::*;
#(
   parameter int unsigned ADDR_BITS = 7,
   parameter int unsigned BYTE_BITS = 8,
   parameter int unsigned CMD_BITS  = ADDR_BITS + 1,
   parameter int unsigned WORD_BITS = 2 * BYTE_BITS,
   parameter int unsigned CNT_W     = $clog2(WORD_BITS + 2)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 wr_i,
   input  logic                 sel_i,
   input  logic                 sdi_i,
   input  logic                 sel_rise_i,
   input  logic                 sel_drop_i,
   input  logic                 sclk_rise_i,
   output logic [ADDR_BITS-1:0] rom_addr_o,
   input  logic [WORD_BITS-1:0] rom_word_i,
   output logic                 sdo_o,
   output logic                 overread_o,
   output logic                 unsup_o
);

   localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_BITS);
   localparam logic [CNT_W-1:0] WORD_END = CNT_W'(WORD_BITS);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_BITS + 1);

   initial begin
      assert (CMD_BITS == ADDR_BITS + 1)
         else $error("srr_seq: command is one read flag bit plus the address");
      assert (CMD_BITS <= WORD_BITS + 1)
         else $error("srr_seq: counter too narrow for command");
   end

   srr_state_e           state_q, state_mid, state_d;
   logic [CMD_BITS-1:0]  cmd_q, cmd_d, cmd_shift;
   logic [WORD_BITS-1:0] word_q, word_d;
   logic [CNT_W-1:0]     cnt_q, cnt_d, cnt_inc;
   logic                 sdo_q, sdo_d;
   logic                 over_q, over_d;
   logic                 unsup_q, unsup_d;

   assign cmd_shift  = {cmd_q[CMD_BITS-2:0], sdi_i};
   assign cnt_inc    = cnt_q + 1'b1;
   assign rom_addr_o = cmd_shift[ADDR_BITS-1:0];

   // Select handling is applied before the clock event of the same write.
   always_comb begin
      state_mid = state_q;
      if (sel_drop_i)      state_mid = ST_IDLE;
      else if (sel_rise_i) state_mid = ST_READY;
   end

   always_comb begin
      state_d = state_mid;
      cmd_d   = cmd_q;
      word_d  = word_q;
      cnt_d   = cnt_q;
      sdo_d   = sdo_q;
      over_d  = over_q;
      unsup_d = unsup_q;
      if (sclk_rise_i) begin
         unique case (state_mid)
            ST_READY: begin
               state_d = ST_CMD;
               cnt_d   = '0;
            end
            ST_CMD: begin
               cmd_d = cmd_shift;
               cnt_d = cnt_inc;
               if (cnt_inc == CMD_LAST) begin
                  cnt_d = '0;
                  if (cmd_shift[CMD_BITS-1]) begin
                     state_d = ST_READ;
                     word_d  = rom_word_i;
                  end else begin
                     state_d = ST_IDLE;
                     unsup_d = 1'b1;
                  end
               end
            end
            ST_READ: begin
               sdo_d  = word_q[WORD_BITS-1];
               word_d = {word_q[WORD_BITS-2:0], 1'b0};
               if (cnt_q != CNT_SAT) cnt_d = cnt_inc;
               if (cnt_q >= WORD_END) over_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         cmd_q   <= '0;
         word_q  <= '0;
         cnt_q   <= '0;
         sdo_q   <= 1'b0;
         over_q  <= 1'b0;
         unsup_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cmd_q   <= cmd_d;
         word_q  <= word_d;
         cnt_q   <= cnt_d;
         sdo_q   <= sdo_d;
         over_q  <= over_d;
         unsup_q <= unsup_d;
      end
   end

   assign sdo_o      = sdo_q;
   assign overread_o = over_q;
   assign unsup_o    = unsup_q;

   // R2
   sel_low_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !sel_i) |=> (state_q == ST_IDLE));
   // R6
   sdo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sclk_rise_i |=> $stable(sdo_q));
   // R7
   overread_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      over_q |=> over_q);
   // R8
   unsup_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unsup_q |=> unsup_q);
   // R4
   cmd_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_CMD) |-> (cnt_q < CMD_LAST));
   // R7
   cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_SAT);

endmodule

// File: rtl/serial_rom_responder.sv
module serial_rom_responder
   import srr_pkg::*;
#(
   parameter int unsigned ADDR_BITS = srr_pkg::DEF_ADDR_BITS,
   parameter int unsigned BYTE_BITS = srr_pkg::DEF_BYTE_BITS,
   parameter bit          REG_STORE = 1'b0,
   parameter logic [((1 << (ADDR_BITS + 1)) * BYTE_BITS)-1:0] INIT_IMAGE = srr_pkg::default_image()
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ctrl_wr_i,
   input  logic ctrl_sel_i,
   input  logic ctrl_sclk_i,
   input  logic ctrl_sdi_i,
   output logic sdo_o,
   output logic overread_o,
   output logic unsup_cmd_o
);

   localparam int unsigned DEPTH     = 1 << (ADDR_BITS + 1);
   localparam int unsigned WORD_BITS = 2 * BYTE_BITS;
   localparam int unsigned CMD_BITS  = ADDR_BITS + 1;

   initial begin
      assert (ADDR_BITS >= 3 && ADDR_BITS <= 10)
         else $error("serial_rom_responder: ADDR_BITS out of range");
      assert (BYTE_BITS >= 2)
         else $error("serial_rom_responder: BYTE_BITS too small");
   end

   logic                 sel_rise, sel_drop, sclk_rise;
   logic [ADDR_BITS-1:0] rom_addr;
   logic [WORD_BITS-1:0] rom_word;

   srr_ctrl_edge i_edge (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (ctrl_wr_i),
      .sel_i       (ctrl_sel_i),
      .sclk_i      (ctrl_sclk_i),
      .sel_rise_o  (sel_rise),
      .sel_drop_o  (sel_drop),
      .sclk_rise_o (sclk_rise)
   );

   srr_word_rom #(
      .ADDR_BITS (ADDR_BITS),
      .BYTE_BITS (BYTE_BITS),
      .REG_STORE (REG_STORE),
      .DEPTH     (DEPTH),
      .IMAGE     (INIT_IMAGE)
   ) i_rom (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .word_addr_i (rom_addr),
      .word_o      (rom_word)
   );

   srr_seq #(
      .ADDR_BITS (ADDR_BITS),
      .BYTE_BITS (BYTE_BITS),
      .CMD_BITS  (CMD_BITS),
      .WORD_BITS (WORD_BITS)
   ) i_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (ctrl_wr_i),
      .sel_i       (ctrl_sel_i),
      .sdi_i       (ctrl_sdi_i),
      .sel_rise_i  (sel_rise),
      .sel_drop_i  (sel_drop),
      .sclk_rise_i (sclk_rise),
      .rom_addr_o  (rom_addr),
      .rom_word_i  (rom_word),
      .sdo_o       (sdo_o),
      .overread_o  (overread_o),
      .unsup_o     (unsup_cmd_o)
   );

   // R9
   no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_wr_i |=> ($stable(sdo_o) && $stable(overread_o) && $stable(unsup_cmd_o)));

endmodule

// File: tb/test_serial_rom_responder.sv
module test_serial_rom_responder;

   localparam int IMG_W = 2048;

   function automatic logic [7:0] tb_byte(input int i);
      logic [47:0] st;
      st = 48'h02_9A_31_C4_07_E5;
      if (i < 6) return st[47 - i*8 -: 8];
      return 8'((i * 29 + 7) & 255);
   endfunction

   function automatic logic [IMG_W-1:0] tb_image();
      logic [IMG_W-1:0] img;
      for (int i = 0; i < 256; i++) img[i*8 +: 8] = tb_byte(i);
      return img;
   endfunction

   localparam logic [IMG_W-1:0] TB_IMAGE = tb_image();

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
   logic sdo, over, unsup;

   always #4 clk = ~clk;

   serial_rom_responder #(.REG_STORE(1'b1), .INIT_IMAGE(TB_IMAGE)) i_serial_rom_responder (
      .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(wr), .ctrl_sel_i(sel),
      .ctrl_sclk_i(sclk), .ctrl_sdi_i(sdi), .sdo_o(sdo),
      .overread_o(over), .unsup_cmd_o(unsup));

   int    n_chk = 0, n_bad = 0;
   bit    done = 0;
   logic  exp_q[$];
   string tag_q[$];
   logic  last_exp = 1'b0;

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // monitor: compares each expected data-out bit after its write
   always @(negedge clk) begin
      #1;
      while (exp_q.size() > 0) begin
         automatic logic  e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         chk(sdo, e, t);
      end
   end

   task automatic wctl(input logic s, input logic c, input logic d);
      @(negedge clk);
      wr = 1'b1; sel = s; sclk = c; sdi = d;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic push(input logic e, input string t);
      last_exp = e;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   // R3: open a transaction, start bit with a chosen data value
   task automatic start_txn(input bit combined, input logic start_d);
      wctl(1'b0, 1'b0, 1'b0);
      if (combined) wctl(1'b1, 1'b1, start_d);
      else begin
         wctl(1'b1, 1'b0, 1'b0);
         wctl(1'b1, 1'b1, start_d);
      end
   endtask

   // R4: eight command bits, first one goes to bit 7
   task automatic send_cmd(input logic [7:0] cmd);
      for (int b = 7; b >= 0; b--) begin
         wctl(1'b1, 1'b0, cmd[b]);
         wctl(1'b1, 1'b1, cmd[b]);
      end
   endtask

   function automatic logic [15:0] exp_word(input logic [7:0] cmd);
      int a;
      a = int'(cmd[6:0]) * 2;
      return {tb_byte(a), tb_byte(a + 1)};
   endfunction

   // R5 R6: clock out n bits and queue the expected stream
   task automatic read_bits(input logic [15:0] w, input int n, input string t);
      for (int k = 0; k < n; k++) begin
         wctl(1'b1, 1'b0, 1'b0);
         wctl(1'b1, 1'b1, 1'b0);
         push((k < 16) ? w[15 - k] : 1'b0, t);
      end
   endtask

   task automatic flag_chk(input logic act, input logic exp, input string t);
      #2;
      chk(act, exp, t);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(sdo,   1'b0, "R1 reset sdo");
      chk(over,  1'b0, "R1 reset overread");
      chk(unsup, 1'b0, "R1 reset unsup");

      // R10 R5: station address word 0, start bit data 1 ignored (R3)
      start_txn(1'b0, 1'b1);
      send_cmd(8'h80);
      read_bits(exp_word(8'h80), 16, "R10 station bytes 0-1");
      start_txn(1'b0, 1'b0);
      send_cmd(8'h82);
      read_bits(exp_word(8'h82), 16, "R10 station bytes 4-5");

      // R5 top of array
      start_txn(1'b0, 1'b0);
      send_cmd(8'hFF);
      read_bits(exp_word(8'hFF), 16, "R5 addr 254-255");

      // R3 select and clock rising in one write
      start_txn(1'b1, 1'b1);
      send_cmd(8'hA5);
      read_bits(exp_word(8'hA5), 16, "R3 combined start");

      // R7 over-read
      start_txn(1'b0, 1'b0);
      send_cmd(8'hC3);
      read_bits(exp_word(8'hC3), 16, "R6 stream before overread");
      flag_chk(over, 1'b0, "R7 no flag at 16 bits");
      read_bits(exp_word(8'hC3), 0, "R7");
      wctl(1'b1, 1'b0, 1'b0);
      wctl(1'b1, 1'b1, 1'b0);
      push(1'b0, "R7 17th bit zero");
      flag_chk(over, 1'b1, "R7 overread set");
      start_txn(1'b0, 1'b0);
      flag_chk(over, 1'b1, "R7 overread sticky");

      // R9 repeated high clock is not an edge
      send_cmd(8'h91);
      read_bits(exp_word(8'h91), 3, "R9 first bits");
      wctl(1'b1, 1'b1, 1'b1);
      wctl(1'b1, 1'b1, 1'b0);
      push(last_exp, "R9 repeated high clock holds");
      @(negedge clk); @(negedge clk);
      push(last_exp, "R9 idle cycles hold");

      // R2 abort mid read
      start_txn(1'b0, 1'b0);
      send_cmd(8'h81);
      read_bits(exp_word(8'h81), 5, "R2 pre-abort bits");
      wctl(1'b0, 1'b0, 1'b0);
      wctl(1'b0, 1'b1, 1'b0);
      push(last_exp, "R2 clock after abort holds");
      wctl(1'b0, 1'b0, 1'b0);
      wctl(1'b0, 1'b1, 1'b1);
      push(last_exp, "R2 second clock after abort holds");

      // R8 unsupported command
      start_txn(1'b0, 1'b0);
      send_cmd(8'h05);
      flag_chk(unsup, 1'b1, "R8 unsup set");
      wctl(1'b1, 1'b0, 1'b0);
      wctl(1'b1, 1'b1, 1'b0);
      push(last_exp, "R8 clock after unsup holds");
      wctl(1'b1, 1'b0, 1'b0);
      wctl(1'b1, 1'b1, 1'b1);
      push(last_exp, "R8 clock after unsup holds again");
      start_txn(1'b0, 1'b0);
      send_cmd(8'hB7);
      read_bits(exp_word(8'hB7), 16, "R8 read after unsup");
      flag_chk(unsup, 1'b1, "R8 unsup sticky");

      repeat (4) @(negedge clk);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule